// File: doc/BRIEF.md
# NAND Copy-Back Program Sequencer

This block sits on the controller side of an 8-bit asynchronous NAND flash bus. It moves one page from a source row to a target row inside the flash device, and it can overwrite chosen bytes on the way. The data does not cross the controller bus except for an optional read-out and the patch bytes. A host pulses `start` with both addresses, an optional read-out length and two mode bits. The block then runs the whole two-phase exchange on its own. When it ends, it pulses `done` with a 2-bit result code.

The first phase loads the device page register with a read-for-copy command pair. The block waits on the ready/busy line and can then stream some page bytes back to the host. The second phase opens a copy-back program at the target address. Patch bytes arrive on a valid/ready stream. Each beat may start a new segment, and a new segment re-addresses the page register with a column-only address. After the last beat the block writes the confirm command. It detects the end of programming either from the ready/busy line or by polling the status register, and it turns the status pass/fail bit into the result code. Every busy wait is bounded by a timeout.

Top module: `nand_cpb_seq`

## Requirements
- R1: After `start`, the first bus writes are command 0x00 with CLE high, then five address bytes with ALE high in this order: source column low, column high, row low, row middle, row high. Command 0x35 follows with CLE high.
- R2: No bus cycle follows the 0x35 command until `nand_rb` reads high. Then `rd_len` read cycles (RE# pulses) run, and each byte appears once on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R3: After the read-out, the block writes command 0x85 and then the five destination address bytes, in the same byte order as R1.
- R4: `patch_ready` is high only while the block waits for a patch beat, and only when `has_patch` was set at start. A beat with `patch_seg`=1 is preceded on the bus by command 0x85 and two column bytes (low first). The patch byte itself is written with CLE and ALE both low.
- R5: Command 0x10 is written right after the beat marked `patch_last`, or right after the destination address when `has_patch` is 0.
- R6: With `use_poll`=0, the block waits for `nand_rb` high after 0x10. It then writes 0x70 once and reads one status byte.
- R7: With `use_poll`=1, the block writes 0x70 once right after 0x10. It then repeats status reads without writing any command until status bit 6 reads 1.
- R8: When status bit 6 is 1, status bit 0 sets `result`: 0 gives 0 (pass) and 1 gives 1 (program fail). `done` is a single-cycle pulse, and `busy` is high from the cycle after `start` until `done`.
- R9: Every WE# or RE# pulse stays low for at least T_LO clock cycles. Between pulses within one operation the strobes stay high for at least T_HI cycles.
- R10: If any busy wait lasts BUSY_TIMEOUT cycles, the block ends the operation with `result`=2. It then writes nothing more, and `nand_ce_n` returns high.
- R11: CLE and ALE are never high together. The data bus is driven only during write cycles, never while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one copy operation (sampled while idle) |
| src_col | input | 16 | Source column address |
| src_row | input | 24 | Source row address |
| dst_col | input | 16 | Destination column address |
| dst_row | input | 24 | Destination row address |
| rd_len | input | 16 | Number of bytes to read out after the source load |
| use_poll | input | 1 | 1: detect program end by status polling; 0: by ready/busy |
| has_patch | input | 1 | 1: accept patch beats before the confirm |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| result | output | 2 | 0 pass, 1 program fail, 2 timeout |
| rd_valid | output | 1 | Read-out byte strobe |
| rd_data | output | 8 | Read-out byte |
| patch_valid | input | 1 | Patch beat offered |
| patch_ready | output | 1 | Patch beat accepted this cycle when valid |
| patch_seg | input | 1 | Beat starts a new column segment |
| patch_last | input | 1 | Final patch beat |
| patch_col | input | 16 | Column of a segment-start beat |
| patch_data | input | 8 | Patch byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with T_LO=2 and T_HI=1. This uneven strobe shape makes a swapped or shortened phase show up in the measured pulse widths. BUSY_TIMEOUT is set to 300 cycles, so a device model that holds ready/busy low for 1000 cycles reaches the timeout path within a short run. A model with a 40-cycle program time then gives several not-ready status reads in polling mode. WB_HOLD stays at 2, so the block ignores ready/busy for two cycles after each busy wait begins.

// File: rtl/nand_cpb_pkg.sv
package nand_cpb_pkg;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_WDAT = 2'd2,
    BK_RDAT = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    RES_PASS  = 2'd0,
    RES_PFAIL = 2'd1,
    RES_TMO   = 2'd2
  } res_e;

  localparam logic [7:0] OP_LOAD    = 8'h00;
  localparam logic [7:0] OP_LOADCPY = 8'h35;
  localparam logic [7:0] OP_CPYPROG = 8'h85;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  localparam int ST_BIT_READY = 6;
  localparam int ST_BIT_FAIL  = 0;

  // Outcome of one status byte once the device reports ready.
  function automatic res_e status_result(input logic [7:0] sb);
    return sb[ST_BIT_FAIL] ? RES_PFAIL : RES_PASS;
  endfunction

endpackage

// File: rtl/nand_cpb_strobe.sv
module nand_cpb_strobe
  import nand_cpb_pkg::*;
#(
  parameter int T_LO = 2,
  parameter int T_HI = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  bus_kind_e kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] io_in,
  output logic      idle,
  output logic      cyc_done,
  output logic [7:0] rbyte,
  output logic      cle,
  output logic      ale,
  output logic      we_n,
  output logic      re_n,
  output logic [7:0] io_out,
  output logic      io_oe
);
  localparam int TMAX  = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int RUN_W = $clog2(TMAX + 2) + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_e;

  phase_e    ph;
  logic [CW-1:0] cnt;
  bus_kind_e kind_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      kind_q <= BK_CMD;
      byte_q <= '0;
      rbyte  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (go) begin
          ph     <= PH_LO;
          cnt    <= CW'(T_LO - 1);
          kind_q <= kind;
          byte_q <= wbyte;
        end
        PH_LO: if (cnt == '0) begin
          ph  <= PH_HI;
          cnt <= CW'(T_HI - 1);
          if (kind_q == BK_RDAT) rbyte <= io_in;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_HI: if (cnt == '0) ph <= PH_IDLE;
               else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign idle     = (ph == PH_IDLE);
  assign cyc_done = (ph == PH_HI) && (cnt == '0);
  assign cle      = (ph != PH_IDLE) && (kind_q == BK_CMD);
  assign ale      = (ph != PH_IDLE) && (kind_q == BK_ADDR);
  assign we_n     = !((ph == PH_LO) && (kind_q != BK_RDAT));
  assign re_n     = !((ph == PH_LO) && (kind_q == BK_RDAT));
  assign io_out   = byte_q;
  assign io_oe    = (ph != PH_IDLE) && (kind_q != BK_RDAT);

  // Pulse-width observers for the checks below.
  logic strobe_lo;
  logic [RUN_W-1:0] lo_run, hi_run;
  assign strobe_lo = !we_n || !re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '1;
    end else if (strobe_lo) begin
      lo_run <= (lo_run == '1) ? lo_run : lo_run + 1'b1;
      hi_run <= '0;
    end else begin
      lo_run <= '0;
      hi_run <= (hi_run == '1) ? hi_run : hi_run + 1'b1;
    end
  end

  assert_lo_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_lo) |-> (int'(lo_run) >= T_LO));
  assert_hi_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_lo) |-> (int'(hi_run) >= T_HI));
  assert_cle_ale_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  assert_bus_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_oe && !re_n));

endmodule

// File: rtl/nand_cpb_waiter.sv
module nand_cpb_waiter #(
  parameter int LIMIT = 1000,
  parameter int HOLD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rb,
  output logic ready_ok,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!en)                  cnt <= '0;
    else if (cnt != CNT_W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign ready_ok = en && (cnt >= CNT_W'(HOLD)) && rb;
  assign expired  = en && (cnt == CNT_W'(LIMIT)) && !ready_ok;

  assert_no_early_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> !expired);

endmodule

// File: rtl/nand_cpb_seq.sv
module nand_cpb_seq
  import nand_cpb_pkg::*;
#(
  parameter int T_LO         = 2,
  parameter int T_HI         = 2,
  parameter int BUSY_TIMEOUT = 100000,
  parameter int WB_HOLD      = 2,
  parameter int COL_BYTES    = 2,
  parameter int ROW_BYTES    = 3,
  parameter int LEN_W        = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*COL_BYTES-1:0] src_col,
  input  logic [8*ROW_BYTES-1:0] src_row,
  input  logic [8*COL_BYTES-1:0] dst_col,
  input  logic [8*ROW_BYTES-1:0] dst_row,
  input  logic [LEN_W-1:0]       rd_len,
  input  logic                   use_poll,
  input  logic                   has_patch,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             result,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  input  logic                   patch_valid,
  output logic                   patch_ready,
  input  logic                   patch_seg,
  input  logic                   patch_last,
  input  logic [8*COL_BYTES-1:0] patch_col,
  input  logic [7:0]             patch_data,
  output logic                   nand_ce_n,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we_n,
  output logic                   nand_re_n,
  output logic [7:0]             nand_io_out,
  output logic                   nand_io_oe,
  input  logic [7:0]             nand_io_in,
  input  logic                   nand_rb
);
  localparam int COL_W    = 8 * COL_BYTES;
  localparam int ROW_W    = 8 * ROW_BYTES;
  localparam int ADDR_W   = COL_W + ROW_W;
  localparam int ADDR_CYC = COL_BYTES + ROW_BYTES;
  localparam int IDX_W    = $clog2(ADDR_CYC + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_C00, ST_SADR, ST_C35, ST_WRD, ST_RDOUT, ST_C85, ST_TADR,
    ST_PWAIT, ST_PC85, ST_PCOL, ST_PDAT, ST_C10, ST_WPG, ST_C70, ST_STAT
  } state_e;

  // Byte i of a packed {row, col} address, column bytes first.
  function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a,
                                           input logic [IDX_W-1:0] i);
    return a[8*int'(i) +: 8];
  endfunction

  state_e            state;
  logic [ADDR_W-1:0] src_a, dst_a;
  logic [LEN_W-1:0]  rd_left;
  logic [IDX_W-1:0]  idx;
  logic              poll_q, patch_q, pend;
  logic [COL_W-1:0]  pcol_q;
  logic [7:0]        pdat_q;
  logic              plast_q;

  // Named internal events
  logic      bus_req, bus_go, st_idle, cyc_done, step;
  bus_kind_e bus_kind;
  logic [7:0] bus_byte, rbyte;
  logic      wt_en, wt_ok, wt_exp;

  always_comb begin
    bus_req  = 1'b1;
    bus_kind = BK_CMD;
    bus_byte = 8'h00;
    case (state)
      ST_C00:   bus_byte = OP_LOAD;
      ST_SADR:  begin bus_kind = BK_ADDR; bus_byte = addr_byte(src_a, idx); end
      ST_C35:   bus_byte = OP_LOADCPY;
      ST_RDOUT: bus_kind = BK_RDAT;
      ST_C85:   bus_byte = OP_CPYPROG;
      ST_TADR:  begin bus_kind = BK_ADDR; bus_byte = addr_byte(dst_a, idx); end
      ST_PC85:  bus_byte = OP_CPYPROG;
      ST_PCOL:  begin bus_kind = BK_ADDR; bus_byte = pcol_q[8*int'(idx) +: 8]; end
      ST_PDAT:  begin bus_kind = BK_WDAT; bus_byte = pdat_q; end
      ST_C10:   bus_byte = OP_CONFIRM;
      ST_C70:   bus_byte = OP_STATUS;
      ST_STAT:  bus_kind = BK_RDAT;
      default:  bus_req = 1'b0;
    endcase
  end

  assign bus_go = bus_req && st_idle && !pend;
  assign step   = pend && cyc_done;
  assign wt_en  = (state == ST_WRD) || (state == ST_WPG) || (state == ST_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      src_a   <= '0;
      dst_a   <= '0;
      rd_left <= '0;
      idx     <= '0;
      poll_q  <= 1'b0;
      patch_q <= 1'b0;
      pend    <= 1'b0;
      pcol_q  <= '0;
      pdat_q  <= '0;
      plast_q <= 1'b0;
      done    <= 1'b0;
      result  <= RES_PASS;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (bus_go) pend <= 1'b1;
      if (step)   pend <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          src_a   <= {src_row, src_col};
          dst_a   <= {dst_row, dst_col};
          rd_left <= rd_len;
          poll_q  <= use_poll;
          patch_q <= has_patch;
          idx     <= '0;
          state   <= ST_C00;
        end
        ST_C00: if (step) begin idx <= '0; state <= ST_SADR; end
        ST_SADR: if (step) begin
          if (idx == IDX_W'(ADDR_CYC - 1)) state <= ST_C35;
          else idx <= idx + 1'b1;
        end
        ST_C35: if (step) state <= ST_WRD;
        ST_WRD: begin
          if (wt_ok) state <= (rd_left == '0) ? ST_C85 : ST_RDOUT;
          else if (wt_exp) begin
            state <= ST_IDLE; done <= 1'b1; result <= RES_TMO; pend <= 1'b0;
          end
        end
        ST_RDOUT: if (step) begin
          rd_valid <= 1'b1;
          rd_data  <= rbyte;
          rd_left  <= rd_left - 1'b1;
          if (rd_left == LEN_W'(1)) state <= ST_C85;
        end
        ST_C85: if (step) begin idx <= '0; state <= ST_TADR; end
        ST_TADR: if (step) begin
          if (idx == IDX_W'(ADDR_CYC - 1)) state <= patch_q ? ST_PWAIT : ST_C10;
          else idx <= idx + 1'b1;
        end
        ST_PWAIT: if (patch_valid) begin
          pcol_q  <= patch_col;
          pdat_q  <= patch_data;
          plast_q <= patch_last;
          idx     <= '0;
          state   <= patch_seg ? ST_PC85 : ST_PDAT;
        end
        ST_PC85: if (step) begin idx <= '0; state <= ST_PCOL; end
        ST_PCOL: if (step) begin
          if (idx == IDX_W'(COL_BYTES - 1)) state <= ST_PDAT;
          else idx <= idx + 1'b1;
        end
        ST_PDAT: if (step) state <= plast_q ? ST_C10 : ST_PWAIT;
        ST_C10:  if (step) state <= poll_q ? ST_C70 : ST_WPG;
        ST_WPG: begin
          if (wt_ok) state <= ST_C70;
          else if (wt_exp) begin
            state <= ST_IDLE; done <= 1'b1; result <= RES_TMO; pend <= 1'b0;
          end
        end
        ST_C70: if (step) state <= ST_STAT;
        ST_STAT: begin
          if (wt_exp) begin
            state <= ST_IDLE; done <= 1'b1; result <= RES_TMO; pend <= 1'b0;
          end else if (step && rbyte[ST_BIT_READY]) begin
            state <= ST_IDLE; done <= 1'b1; result <= status_result(rbyte);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  nand_cpb_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(bus_go), .kind(bus_kind), .wbyte(bus_byte),
    .io_in(nand_io_in), .idle(st_idle), .cyc_done(cyc_done), .rbyte(rbyte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe)
  );

  nand_cpb_waiter #(.LIMIT(BUSY_TIMEOUT), .HOLD(WB_HOLD)) u_waiter (
    .clk(clk), .rst_n(rst_n), .en(wt_en), .rb(nand_rb),
    .ready_ok(wt_ok), .expired(wt_exp)
  );

  assign busy        = (state != ST_IDLE);
  assign patch_ready = (state == ST_PWAIT);
  assign nand_ce_n   = !(busy || !st_idle);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_ready_in_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    patch_ready |-> (busy && patch_q));
  assert_timeout_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_en && wt_exp) |=> (done && result == RES_TMO));
  assert_no_cmd_in_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAT) |-> !nand_cle);
  assert_wait_before_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRD && !nand_rb) |=> (state != ST_RDOUT && state != ST_C85));

endmodule

// File: tb/nand_cpb_seq_bench.sv
module nand_cpb_seq_bench;
  localparam int T_LO = 2;
  localparam int T_HI = 1;
  localparam int TMO  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, use_poll = 0, has_patch = 0;
  logic [15:0] src_col = 0, dst_col = 0, rd_len = 0, patch_col = 0;
  logic [23:0] src_row = 0, dst_row = 0;
  logic patch_valid = 0, patch_seg = 0, patch_last = 0;
  logic [7:0] patch_data = 0;
  logic [7:0] nand_io_in = 0;
  logic nand_rb = 1;
  logic busy, done, rd_valid, patch_ready;
  logic [1:0] result;
  logic [7:0] rd_data, nand_io_out;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;

  nand_cpb_seq #(.T_LO(T_LO), .T_HI(T_HI), .BUSY_TIMEOUT(TMO), .WB_HOLD(2)) u_nand_cpb_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .src_col(src_col), .src_row(src_row),
    .dst_col(dst_col), .dst_row(dst_row), .rd_len(rd_len), .use_poll(use_poll),
    .has_patch(has_patch), .busy(busy), .done(done), .result(result),
    .rd_valid(rd_valid), .rd_data(rd_data), .patch_valid(patch_valid),
    .patch_ready(patch_ready), .patch_seg(patch_seg), .patch_last(patch_last),
    .patch_col(patch_col), .patch_data(patch_data), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues: write items are {cle, ale, byte}.
  logic [9:0] exp_w[$];
  string      exp_tag[$];
  logic [7:0] exp_rd[$];
  logic [1:0] got_res;
  bit         got_done = 0;

  // Device model settings
  int  tr_len = 20, tp_len = 40;
  bit  fail_flag = 0;
  int  stat_reads = 0;
  int  min_lo = 1000, min_hi = 1000;

  task automatic push_w(input logic [1:0] ca, input logic [7:0] b, input string tag);
    exp_w.push_back({ca, b});
    exp_tag.push_back(tag);
  endtask

  // Model + monitor, acting at the falling edge only.
  initial begin
    logic [7:0] last_cmd = 8'hFF;
    int pg_idx = 0, rb_cnt = 0, lo_cnt = 0, hi_cnt = 0;
    bit prev_s = 1, prev_we = 1, prev_re = 1, armed = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      // write monitor
      if (nand_we_n && !prev_we) begin
        logic [9:0] item;
        item = {nand_cle, nand_ale, nand_io_out};
        if (exp_w.size() == 0) begin
          check(0, "R5", "unexpected bus write", int'(item), 0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_w.pop_front();
          t = exp_tag.pop_front();
          check(item == e, t, "bus write {cle,ale,byte}", int'(item), int'(e));
        end
        if (nand_cle) begin
          last_cmd = nand_io_out;
          if (nand_io_out == 8'h35) begin nand_rb = 0; rb_cnt = tr_len; pg_idx = 0; end
          if (nand_io_out == 8'h10) begin nand_rb = 0; rb_cnt = tp_len; end
        end
      end
      if (nand_re_n && !prev_re) begin
        if (last_cmd == 8'h70) stat_reads++;
        else pg_idx++;
      end
      if (!nand_rb) begin
        rb_cnt--;
        if (rb_cnt <= 0) nand_rb = 1;
      end
      nand_io_in = (last_cmd == 8'h70) ? {1'b0, nand_rb, 5'b0, fail_flag & nand_rb}
                                       : (8'h5A ^ pg_idx[7:0]);
      // strobe widths
      begin
        bit s;
        s = nand_we_n && nand_re_n;
        if (!s) lo_cnt++;
        else if (armed) hi_cnt++;
        if (s && !prev_s) begin
          if (lo_cnt < min_lo) min_lo = lo_cnt;
          lo_cnt = 0; armed = 1; hi_cnt = 0;
        end
        if (!s && prev_s && armed && hi_cnt < min_hi) min_hi = hi_cnt;
        if (nand_ce_n) armed = 0;
        prev_s = s;
      end
      if (nand_cle && nand_ale) check(0, "R11", "CLE and ALE together", 1, 0);
      if (nand_io_oe && !nand_re_n) check(0, "R11", "bus driven during read", 1, 0);
      // read-out monitor
      if (rd_valid) begin
        if (exp_rd.size() == 0) check(0, "R2", "extra read-out byte", int'(rd_data), 0);
        else begin
          logic [7:0] eb;
          eb = exp_rd.pop_front();
          check(rd_data == eb, "R2", "read-out byte", int'(rd_data), int'(eb));
        end
      end
      if (done) begin got_done = 1; got_res = result; end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  // Patch beats for the next operation
  logic [15:0] pb_col[8];
  logic [7:0]  pb_dat[8];
  bit          pb_seg[8];
  int          npb = 0;

  task automatic feed_patches();
    for (int i = 0; i < npb; i++) begin
      patch_valid = 1; patch_col = pb_col[i]; patch_data = pb_dat[i];
      patch_seg = pb_seg[i]; patch_last = (i == npb - 1);
      while (!patch_ready) @(negedge clk);
      @(negedge clk);
    end
    patch_valid = 0; patch_last = 0; patch_seg = 0;
  endtask

  task automatic push_addr(input logic [15:0] c, input logic [23:0] r, input string tag);
    push_w(2'b01, c[7:0], tag);   push_w(2'b01, c[15:8], tag);
    push_w(2'b01, r[7:0], tag);   push_w(2'b01, r[15:8], tag);
    push_w(2'b01, r[23:16], tag);
  endtask

  // Driver: predicts the whole bus conversation, then runs it.
  task automatic run_op(input string name, input bit poll, input bit pat, input int rdl,
                        input bit fl, input int tr, input logic [1:0] eres,
                        input bit tmo_case);
    tr_len = tr; fail_flag = fl; stat_reads = 0; min_lo = 1000; min_hi = 1000;
    got_done = 0;
    src_col = 16'h0100 + 16'(rdl); src_row = 24'h0A0B0C ^ 24'(tr);
    dst_col = 16'h0200; dst_row = 24'h123456 + 24'(rdl);
    push_w(2'b10, 8'h00, "R1");
    push_addr(src_col, src_row, "R1");
    push_w(2'b10, 8'h35, "R1");
    if (!tmo_case) begin
      for (int i = 0; i < rdl; i++) exp_rd.push_back(8'h5A ^ 8'(i));
      push_w(2'b10, 8'h85, "R3");
      push_addr(dst_col, dst_row, "R3");
      if (pat) for (int i = 0; i < npb; i++) begin
        if (pb_seg[i]) begin
          push_w(2'b10, 8'h85, "R4");
          push_w(2'b01, pb_col[i][7:0], "R4");
          push_w(2'b01, pb_col[i][15:8], "R4");
        end
        push_w(2'b00, pb_dat[i], "R4");
      end
      push_w(2'b10, 8'h10, "R5");
      push_w(2'b10, 8'h70, poll ? "R7" : "R6");
    end
    use_poll = poll; has_patch = pat; rd_len = 16'(rdl);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R8", {name, " busy after start"}, int'(busy), 1);
    fork
      if (pat) feed_patches();
      while (!got_done) @(negedge clk);
    join
    check(got_res == eres, (eres == 2) ? "R10" : "R8", {name, " result"},
          int'(got_res), int'(eres));
    @(negedge clk);
    check(done == 1'b0, "R8", {name, " done one cycle"}, int'(done), 0);
    check(busy == 1'b0, "R8", {name, " busy cleared"}, int'(busy), 0);
    repeat (20) @(negedge clk);
    check(exp_w.size() == 0, tmo_case ? "R10" : "R5", {name, " writes left over"},
          exp_w.size(), 0);
    check(exp_rd.size() == 0, "R2", {name, " read-out bytes missing"}, exp_rd.size(), 0);
    check(nand_ce_n == 1'b1, "R10", {name, " chip enable released"}, int'(nand_ce_n), 1);
    if (!tmo_case) begin
      check(min_lo >= T_LO, "R9", {name, " strobe low width"}, min_lo, T_LO);
      check(min_hi >= T_HI, "R9", {name, " strobe high width"}, min_hi, T_HI);
      if (poll) check(stat_reads > 1, "R7", {name, " repeated status reads"}, stat_reads, 2);
      else      check(stat_reads == 1, "R6", {name, " single status read"}, stat_reads, 1);
    end
    exp_w.delete(); exp_tag.delete(); exp_rd.delete();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R8", "reset busy/done", {busy, done}, 0);
    check(nand_ce_n && nand_we_n && nand_re_n, "R9", "reset strobes high",
          {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    check(!nand_cle && !nand_ale && !nand_io_oe, "R11", "reset latches low",
          {nand_cle, nand_ale, nand_io_oe}, 0);
    check(patch_ready == 0, "R4", "reset patch_ready", int'(patch_ready), 0);

    // 1: ready/busy mode, no patches, no read-out, pass
    npb = 0;
    run_op("plain", 0, 0, 0, 0, 20, 2'd0, 0);

    // 2: read-out of 3 bytes, two segments, program fail
    npb = 3;
    pb_col[0] = 16'h0123; pb_dat[0] = 8'h11; pb_seg[0] = 1;
    pb_col[1] = 16'h0000; pb_dat[1] = 8'h22; pb_seg[1] = 0;
    pb_col[2] = 16'h0456; pb_dat[2] = 8'h33; pb_seg[2] = 1;
    run_op("patched", 0, 1, 3, 1, 25, 2'd1, 0);

    // 3: polling mode, one continuation beat, pass
    npb = 1;
    pb_col[0] = 16'h0000; pb_dat[0] = 8'h77; pb_seg[0] = 0;
    run_op("polled", 1, 1, 1, 0, 15, 2'd0, 0);

    // 4: source load never finishes: timeout
    npb = 0;
    run_op("timeout", 0, 0, 0, 0, 1000, 2'd2, 1);
    repeat (1100) @(negedge clk);

    // 5: recovery after timeout, polling with program fail
    run_op("recover", 1, 0, 2, 1, 10, 2'd1, 0);

    summary();
    $finish;
  end
endmodule